// File: doc/BRIEF.md
# Single-Master Two-Slave Bus Fabric with Bypass Self-Test

This block is a small AHB-Lite fabric that connects one bus master to two on-chip memory slaves. An address decoder splits a 128 KiB map into two halves, one per slave, and raises a select line for the matching half. The select is registered at the end of the address phase. During the data phase, a read-data multiplexer uses that registered select to return the chosen slave's data. Both slaves run with zero wait states. A read that directly follows a write to the same word gets the new data through forwarding. A transfer of any size other than a 32-bit word is rejected with the two-cycle error response.

For interconnect test, a test enable switches both slaves to bypass. In bypass, the write data of the current data phase is driven straight back into the read path. An equality checker compares what comes back through the multiplexer against the pattern the master is driving. It reports a single pass/fail flag. With test mode off, the flag rests at 1 and the normal memory path is not affected. A stuck-at defect on a multiplexer data bit can be modelled through two parameters, so the checker's ability to catch such a defect can be shown.

Top module: `ahbt_fabric`

## Requirements
- R1: `sel_lo` is 1 and `sel_hi` is 0 when `haddr[16]` is 0. The two values swap when `haddr[16]` is 1. Both are combinational decodes of the address.
- R2: A word written at an address can be read back from the same address. The two halves of the map hold independent data at the same lower address.
- R3: A read in the address phase right after a write data phase to the same word returns the newly written value, with no wait state.
- R4: The read data in a data phase comes from the slave chosen by the previous address phase, even when the current address points at the other slave.
- R5: Transfers with `hsize` = 3'b010 (word) complete with `hready` = 1 and `hresp` = 0 (OKAY).
- R6: An active transfer (`htrans[1]` = 1) with any other `hsize` gets an error response. In the first cycle `hresp` = 1 and `hready` = 0. In the second cycle `hresp` = 1 and `hready` = 1. Memory is left unchanged.
- R7: While `test_en` = 1, `hrdata` in each data phase equals `hwdata` of that same phase, for reads and writes to either slave. Writes in this mode still update memory.
- R8: While `test_en` = 1, `no_err` is set after each data phase to 1 if `hrdata` equalled `hwdata` and to 0 otherwise. It keeps that value through cycles with no data phase.
- R9: When `test_en` = 0, `no_err` reads 1 from the cycle after the enable falls. Read and write behaviour is the same as without test mode.
- R10: After reset, `hready` = 1, `hresp` = 0, `no_err` = 1 and `hrdata` = 0.
- R11: With the stuck-at parameters set, a bypass data phase whose pattern differs from the stuck value at that bit drives `no_err` to 0 one cycle later. A pattern that agrees at that bit leaves it at 1.
- R12: Transfers with `htrans` IDLE (2'b00) or BUSY (2'b01) never write memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| haddr | input | 17 | Byte address from the master |
| htrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size; only 3'b010 (word) is accepted |
| hwdata | input | 32 | Write data / test pattern, data phase |
| test_en | input | 1 | Bypass test enable |
| hrdata | output | 32 | Read data returned through the multiplexer |
| hready | output | 1 | Transfer done |
| hresp | output | 1 | 1 = error response |
| sel_lo | output | 1 | Select for the lower-half slave |
| sel_hi | output | 1 | Select for the upper-half slave |
| no_err | output | 1 | Bypass comparison result, 1 = pass |

## Verification
A wrong data-phase select register shows up on `hrdata` in the very next data phase. It surfaces as the other slave's data or as zero, and it is most visible in back-to-back reads that alternate between halves. A broken forwarding register or write-enable pipeline appears only on a later read of the affected word: stale data either on the immediate read-after-write or after idle and error transfers. A fault in the error state machine shows on `hready`/`hresp` within two cycles of the bad transfer. A fault in the bypass or checker path changes `no_err` exactly one cycle after the compared data phase.

// File: rtl/ahbt_pkg.sv
package ahbt_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [2:0] SZ_WORD   = 3'b010;
  localparam int         NSLV      = 2;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_WAIT = 2'b01,
    ERR_DONE = 2'b10
  } err_state_e;
endpackage

// File: rtl/ahbt_addr_decode.sv
module ahbt_addr_decode #(
  parameter int ADDR_W  = 17,
  parameter int SEL_BIT = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0]         haddr,
  output logic [ahbt_pkg::NSLV-1:0] sel
);
  // one bit splits the map into two equal halves
  always_comb begin
    sel    = '0;
    sel[0] = ~haddr[SEL_BIT];
    sel[1] =  haddr[SEL_BIT];
  end
endmodule

// File: rtl/ahbt_mem_slave.sv
module ahbt_mem_slave #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              bypass,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] fwd_q;
  logic              fwd;
  logic              dp_wr;
  logic [IDX_W-1:0]  dp_idx;

  // write port: data arrives in the data phase
  always_ff @(posedge clk) begin
    if (dp_wr) mem[dp_idx] <= hwdata;
  end

  // synchronous read port launched in the address phase
  always_ff @(posedge clk) begin
    if (acc && !acc_wr) ram_q <= mem[acc_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_wr  <= 1'b0;
      dp_idx <= '0;
      fwd    <= 1'b0;
      fwd_q  <= '0;
    end else begin
      dp_wr <= acc && acc_wr;
      if (acc) dp_idx <= acc_idx;
      if (acc && !acc_wr) begin
        fwd   <= dp_wr && (dp_idx == acc_idx);
        fwd_q <= hwdata;
      end
    end
  end

  always_comb begin
    if (bypass)   rdata = hwdata;
    else if (fwd) rdata = fwd_q;
    else          rdata = ram_q;
  end
endmodule

// File: rtl/ahbt_resp_mux.sv
module ahbt_resp_mux #(
  parameter int   DATA_W    = 32,
  parameter int   STUCK_BIT = -1,
  parameter logic STUCK_VAL = 1'b0
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   hready,
  input  logic [ahbt_pkg::NSLV-1:0]              addr_sel,
  input  logic [ahbt_pkg::NSLV-1:0][DATA_W-1:0]  slv_rdata,
  output logic [ahbt_pkg::NSLV-1:0]              dp_sel,
  output logic [DATA_W-1:0]                      hrdata
);
  logic [DATA_W-1:0] raw;

  always_ff @(posedge clk) begin
    if (rst)         dp_sel <= '0;
    else if (hready) dp_sel <= addr_sel;
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < ahbt_pkg::NSLV; i++) begin
      if (dp_sel[i]) raw = raw | slv_rdata[i];
    end
  end

  generate
    if (STUCK_BIT >= 0 && STUCK_BIT < DATA_W) begin : g_stuck
      always_comb begin
        hrdata            = raw;
        hrdata[STUCK_BIT] = STUCK_VAL;
      end
    end else begin : g_clean
      assign hrdata = raw;
    end
  endgenerate
endmodule

// File: rtl/ahbt_bypass_check.sv
module ahbt_bypass_check #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_en,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] hrdata,
  input  logic [DATA_W-1:0] hwdata,
  output logic              no_err
);
  always_ff @(posedge clk) begin
    if (rst)                       no_err <= 1'b1;
    else if (!test_en)             no_err <= 1'b1;
    else if (cmp_valid)            no_err <= (hrdata == hwdata);
  end

  // R9
  idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> no_err);

  // R8
  flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(no_err) |-> $past(test_en && cmp_valid));
endmodule

// File: rtl/ahbt_fabric.sv
module ahbt_fabric #(
  parameter int   ADDR_W    = 17,
  parameter int   DATA_W    = 32,
  parameter int   MEM_WORDS = 1024,
  parameter int   STUCK_BIT = -1,
  parameter logic STUCK_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              test_en,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic              hresp,
  output logic              sel_lo,
  output logic              sel_hi,
  output logic              no_err
);
  import ahbt_pkg::*;

  localparam int IDX_W   = $clog2(MEM_WORDS);
  localparam int SEL_BIT = ADDR_W - 1;

  logic [NSLV-1:0]             sel;
  logic [NSLV-1:0]             acc;
  logic [NSLV-1:0]             dp_sel;
  logic [NSLV-1:0][DATA_W-1:0] slv_rdata;
  logic                        active;
  logic                        size_ok;
  logic                        bad_xfer;
  err_state_e                  err_q;
  logic                        unused_addr_bits;

  assign unused_addr_bits = ^{haddr[1:0], haddr[SEL_BIT-1:2+IDX_W], htrans[0]};

  ahbt_addr_decode #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_dec (
    .haddr (haddr),
    .sel   (sel)
  );

  assign sel_lo   = sel[0];
  assign sel_hi   = sel[1];
  assign active   = hready && htrans[1];
  assign size_ok  = (hsize == SZ_WORD);
  assign bad_xfer = active && !size_ok;

  generate
    for (genvar s = 0; s < NSLV; s++) begin : g_slv
      assign acc[s] = active && size_ok && sel[s];
      ahbt_mem_slave #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc[s]),
        .acc_wr  (hwrite),
        .acc_idx (haddr[2 +: IDX_W]),
        .hwdata  (hwdata),
        .bypass  (test_en),
        .rdata   (slv_rdata[s])
      );
    end
  endgenerate

  ahbt_resp_mux #(.DATA_W(DATA_W), .STUCK_BIT(STUCK_BIT), .STUCK_VAL(STUCK_VAL)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .hready    (hready),
    .addr_sel  (acc),
    .slv_rdata (slv_rdata),
    .dp_sel    (dp_sel),
    .hrdata    (hrdata)
  );

  ahbt_bypass_check #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_en   (test_en),
    .cmp_valid ((|dp_sel) && hready),
    .hrdata    (hrdata),
    .hwdata    (hwdata),
    .no_err    (no_err)
  );

  // two-cycle error response for non-word transfers
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= ERR_NONE;
    end else begin
      unique case (err_q)
        ERR_NONE: if (bad_xfer) err_q <= ERR_WAIT;
        ERR_WAIT: err_q <= ERR_DONE;
        ERR_DONE: err_q <= bad_xfer ? ERR_WAIT : ERR_NONE;
        default:  err_q <= ERR_NONE;
      endcase
    end
  end

  assign hready = (err_q != ERR_WAIT);
  assign hresp  = (err_q != ERR_NONE);

  // R6
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hready) |=> (hresp && hready));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hready) |-> $past(htrans[1] && hsize != SZ_WORD));

  generate
    if (STUCK_BIT < 0) begin : g_pass_chk
      // R7
      bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (test_en && (|dp_sel) && hready) |-> (hrdata == hwdata));
    end
  endgenerate
endmodule

// File: tb/ahbt_fabric_tb_top.sv
module ahbt_fabric_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic [31:0] hwdata = '0;
  logic        test_en = 1'b0;
  logic [31:0] hrdata, hrdata_f;
  logic        hready, hresp, sel_lo, sel_hi, no_err;
  logic        hready_f, hresp_f, sel_lo_f, sel_hi_f, no_err_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ahbt_fabric dut_i (
    .clk(clk), .rst(rst), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata), .test_en(test_en), .hrdata(hrdata),
    .hready(hready), .hresp(hresp), .sel_lo(sel_lo), .sel_hi(sel_hi), .no_err(no_err)
  );

  ahbt_fabric #(.STUCK_BIT(3), .STUCK_VAL(1'b0)) dut_flt (
    .clk(clk), .rst(rst), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata), .test_en(test_en), .hrdata(hrdata_f),
    .hready(hready_f), .hresp(hresp_f), .sel_lo(sel_lo_f), .sel_hi(sel_hi_f), .no_err(no_err_f)
  );

  // scoreboard state
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] model [int];
  logic [31:0] pend_wd = '0;
  bit          nxt_chk = 0;
  bit          dp_chk  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issues one address phase and drives the previous transfer's write data
  task automatic issue(input logic wr, input logic [1:0] tr, input logic [16:0] a,
                       input logic [31:0] d, input logic [2:0] sz, input string req);
    @(negedge clk);
    hwdata = pend_wd;
    haddr  = a;
    htrans = tr;
    hwrite = wr;
    hsize  = sz;
    dp_chk = nxt_chk;
    nxt_chk = tr[1] && (sz == 3'b010) && (!wr || test_en);
    if (nxt_chk) begin
      exp_q.push_back(test_en ? d : (model.exists(int'(a)) ? model[int'(a)] : 32'hx));
      tag_q.push_back(req);
    end
    if (tr[1] && sz == 3'b010 && wr) model[int'(a)] = d;
    pend_wd = d;
    #2;
  endtask

  task automatic idle();
    issue(1'b0, 2'b00, 17'h0, 32'h0, 3'b010, "");
  endtask

  // monitor: compares each checked data phase against the queue
  always @(negedge clk) begin
    #1;
    if (dp_chk && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, hrdata, e);
      chk("R5 hready", {31'b0, hready}, 32'd1);
      chk("R5 hresp", {31'b0, hresp}, 32'd0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R10
    chk("R10 hready", {31'b0, hready}, 32'd1);
    chk("R10 hresp", {31'b0, hresp}, 32'd0);
    chk("R10 no_err", {31'b0, no_err}, 32'd1);
    chk("R10 hrdata", hrdata, 32'd0);

    // R1 decode
    haddr = 17'h00010; #1;
    chk("R1 sel_lo low half", {31'b0, sel_lo}, 32'd1);
    chk("R1 sel_hi low half", {31'b0, sel_hi}, 32'd0);
    haddr = 17'h10010; #1;
    chk("R1 sel_lo high half", {31'b0, sel_lo}, 32'd0);
    chk("R1 sel_hi high half", {31'b0, sel_hi}, 32'd1);

    // R2 / R4: independent halves, alternating reads
    issue(1'b1, 2'b10, 17'h00010, 32'hA5A5_0001, 3'b010, "R2");
    issue(1'b1, 2'b10, 17'h10010, 32'hB6B6_0002, 3'b010, "R2");
    idle();
    issue(1'b0, 2'b10, 17'h00010, 32'h0, 3'b010, "R2 low read");
    issue(1'b0, 2'b10, 17'h10010, 32'h0, 3'b010, "R4 high after low");
    issue(1'b0, 2'b10, 17'h00010, 32'h0, 3'b010, "R4 low after high");
    idle();

    // R3 read right after write to same word
    issue(1'b1, 2'b10, 17'h00020, 32'hC3C3_0003, 3'b010, "R3");
    issue(1'b0, 2'b10, 17'h00020, 32'h0, 3'b010, "R3 forwarded read");
    idle();

    // R12 idle and busy with write set
    issue(1'b1, 2'b00, 17'h00010, 32'hDEAD_0004, 3'b010, "R12");
    issue(1'b1, 2'b01, 17'h10010, 32'hDEAD_0005, 3'b010, "R12");
    issue(1'b0, 2'b10, 17'h00010, 32'h0, 3'b010, "R12 low unchanged");
    issue(1'b0, 2'b10, 17'h10010, 32'h0, 3'b010, "R12 high unchanged");
    idle();

    // R6 error response on byte size
    issue(1'b1, 2'b10, 17'h00010, 32'hEEEE_0006, 3'b000, "R6");
    idle();
    chk("R6 first hresp", {31'b0, hresp}, 32'd1);
    chk("R6 first hready", {31'b0, hready}, 32'd0);
    idle();
    chk("R6 second hresp", {31'b0, hresp}, 32'd1);
    chk("R6 second hready", {31'b0, hready}, 32'd1);
    issue(1'b0, 2'b10, 17'h00010, 32'h0, 3'b010, "R6 memory unchanged");
    idle();
    chk("R6 back to okay", {31'b0, hresp}, 32'd0);

    // R7/R8/R11 bypass test
    test_en = 1'b1;
    issue(1'b1, 2'b10, 17'h00030, 32'h0000_00F8, 3'b010, "R7 write pass");
    issue(1'b0, 2'b10, 17'h10040, 32'h1234_5670, 3'b010, "R7 read pass");
    idle();
    chk("R8 clean after pass", {31'b0, no_err}, 32'd1);
    chk("R11 fault bit3 set drops flag", {31'b0, no_err_f}, 32'd0);
    idle();
    chk("R11 fault bit3 clear passes", {31'b0, no_err_f}, 32'd1);
    issue(1'b1, 2'b10, 17'h10044, 32'hFFFF_FFFF, 3'b010, "R7 write high");
    idle();
    idle();
    chk("R11 fault all ones", {31'b0, no_err_f}, 32'd0);
    idle();
    chk("R8 flag held", {31'b0, no_err_f}, 32'd0);
    chk("R8 clean still pass", {31'b0, no_err}, 32'd1);

    // R9 leave test mode
    test_en = 1'b0;
    idle();
    chk("R9 flag back to one", {31'b0, no_err_f}, 32'd1);
    issue(1'b0, 2'b10, 17'h00030, 32'h0, 3'b010, "R7 bypass write stored");
    issue(1'b0, 2'b10, 17'h10044, 32'h0, 3'b010, "R7 bypass write stored high");
    issue(1'b0, 2'b10, 17'h00010, 32'h0, 3'b010, "R9 normal path");
    idle();
    chk("R9 clean flag", {31'b0, no_err}, 32'd1);
    idle();
    finish_run();
  end
endmodule